// File: doc/BRIEF.md
# Packed Saturating Add/Subtract Unit

This block is the packed-integer arithmetic slice of a processor execute stage. It takes two 32-bit source words and a 3-bit operation code and returns one 32-bit word holding independent lane results. The word is split either into two signed 16-bit halves or into four signed 8-bit bytes. Each lane adds or subtracts with signed saturation: a lane that overflows is clamped to the nearest representable extreme instead of wrapping.

Two of the halfword operations cross the operands. The low half of the first source is paired with the high half of the second source, and the high half of the first source with the low half of the second. One lane subtracts and the other adds. Overflow is found from the lane sign bits alone, so no lane ever needs a wider intermediate. A lane flag vector shows which lanes clamped. Two codes are reserved. They give a zero result and raise an illegal-operation output.

By default the result goes through one output register. That register loads only on cycles where `valid_i` is high, and `valid_o` goes high one clock later. A synchronous active-high reset clears both the register and `valid_o`.

Top module: `sat_simd_unit`

## Requirements
- R1: While `rst_i` is high at a clock edge, `valid_o`, `result_o`, `sat_o` and `illegal_o` are all zero after that edge.
- R2: Code 0 adds the halves pairwise. The result low half (bits 15:0) is a[15:0]+b[15:0] and the result high half (bits 31:16) is a[31:16]+b[31:16], each as signed saturating sums.
- R3: Code 3 subtracts the halves pairwise. The result low half is a[15:0]-b[15:0] and the result high half is a[31:16]-b[31:16], both saturating.
- R4: Code 1 is the cross form subtract-low/add-high. The result low half is a[15:0]-b[31:16] and the result high half is a[31:16]+b[15:0], both saturating.
- R5: Code 2 is the cross form add-low/subtract-high. The result low half is a[15:0]+b[31:16] and the result high half is a[31:16]-b[15:0], both saturating.
- R6: Code 4 adds bytes. Result byte i (bits 8i+7:8i) is the saturating sum of byte i of a and byte i of b, for i = 0..3. Each byte is independent of the others.
- R7: Code 7 subtracts bytes. Result byte i is the saturating difference of byte i of a minus byte i of b, with no carry or borrow between bytes.
- R8: A lane that overflows gives the most negative lane value (0x8000 or 0x80) when the first source lane is negative, and the most positive value (0x7FFF or 0x7F) otherwise. A lane that does not overflow gives the exact result.
- R9: `sat_o` bit i is set when byte lane i clamped in byte modes. In halfword modes, bit 0 reports the low half and bit 2 the high half, and bits 1 and 3 are zero.
- R10: Codes 5 and 6 give `result_o` = 0, `sat_o` = 0 and `illegal_o` = 1. Every other code gives `illegal_o` = 0.
- R11: `valid_o` equals `valid_i` delayed by one clock. On a cycle with `valid_i` low, the outputs keep their values whatever the operands and code do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | Operands and code are valid; load the output register |
| op_i | input | 3 | Operation code |
| src_a_i | input | 32 | First source word |
| src_b_i | input | 32 | Second source word |
| valid_o | output | 1 | Result valid, one clock after `valid_i` |
| result_o | output | 32 | Packed lane results |
| sat_o | output | 4 | Per-lane clamp flags |
| illegal_o | output | 1 | Reserved code was issued |

## Verification
Each operation code is driven with four kinds of operands:
- Small in-range values, which show the lane routing, including which half of the second source feeds which lane.
- Positive-plus-positive and negative-minus-positive pairs, which push each lane to its positive and negative clamp.
- Mixed-sign pairs near the limits. These must not clamp, which separates true sign-bit overflow from a naive carry-out test.
- Words in which only one lane overflows, which show that the flag bits and clamping stay confined to that lane.

A seeded pseudo-random sweep over every code is compared against a wide-integer reference model. Hold and reserved-code cases confirm that nothing leaks through when `valid_i` is low or when the code is illegal.

// File: rtl/sat_simd_pkg.sv
package sat_simd_pkg;

    typedef enum logic [2:0] {
        OP_H_ADD  = 3'd0,
        OP_H_XSA  = 3'd1,
        OP_H_XAS  = 3'd2,
        OP_H_SUB  = 3'd3,
        OP_B_ADD  = 3'd4,
        OP_RSV_5  = 3'd5,
        OP_RSV_6  = 3'd6,
        OP_B_SUB  = 3'd7
    } simd_op_e;

    function automatic logic op_is_reserved(input logic [2:0] op);
        return (op == OP_RSV_5) || (op == OP_RSV_6);
    endfunction

    function automatic logic op_is_byte(input logic [2:0] op);
        return (op == OP_B_ADD) || (op == OP_B_SUB);
    endfunction

endpackage

// File: rtl/sat_addsub_lane.sv
module sat_addsub_lane #(
    parameter int W = 8
) (
    input  logic [W-1:0] opa_i,
    input  logic [W-1:0] opb_i,
    input  logic         sub_i,
    output logic [W-1:0] res_o,
    output logic         sat_o
);
    localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] MAX_NEG = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] wrap_c;
    logic         sa_c, sb_c, sr_c, ovf_c;

    always_comb begin
        wrap_c = sub_i ? (opa_i - opb_i) : (opa_i + opb_i);
        sa_c   = opa_i[W-1];
        sb_c   = opb_i[W-1];
        sr_c   = wrap_c[W-1];
        // add overflows on like signs, subtract on unlike signs; both need a sign flip
        ovf_c  = (sr_c != sa_c) && (sub_i ? (sa_c != sb_c) : (sa_c == sb_c));
        if (ovf_c) begin
            res_o = sa_c ? MAX_NEG : MAX_POS;
        end else begin
            res_o = wrap_c;
        end
        sat_o = ovf_c;
    end
endmodule

// File: rtl/sat_simd_route.sv
module sat_simd_route
    import sat_simd_pkg::*;
#(
    parameter int HALF_W = 16
) (
    input  logic [2:0]                 op_i,
    input  logic [2*HALF_W-1:0]        src_a_i,
    input  logic [2*HALF_W-1:0]        src_b_i,
    output logic [1:0][HALF_W-1:0]     h_opa_o,
    output logic [1:0][HALF_W-1:0]     h_opb_o,
    output logic [1:0]                 h_sub_o,
    output logic                       b_sub_o
);
    logic [HALF_W-1:0] a_lo, a_hi, b_lo, b_hi;

    always_comb begin
        a_lo = src_a_i[HALF_W-1:0];
        a_hi = src_a_i[2*HALF_W-1:HALF_W];
        b_lo = src_b_i[HALF_W-1:0];
        b_hi = src_b_i[2*HALF_W-1:HALF_W];

        h_opa_o[0] = a_lo;
        h_opa_o[1] = a_hi;
        h_opb_o[0] = b_lo;
        h_opb_o[1] = b_hi;
        h_sub_o    = 2'b00;
        b_sub_o    = (op_i == OP_B_SUB);

        unique case (op_i)
            OP_H_ADD: h_sub_o = 2'b00;
            OP_H_SUB: h_sub_o = 2'b11;
            OP_H_XSA: begin
                h_opb_o[0] = b_hi;
                h_opb_o[1] = b_lo;
                h_sub_o    = 2'b01;
            end
            OP_H_XAS: begin
                h_opb_o[0] = b_hi;
                h_opb_o[1] = b_lo;
                h_sub_o    = 2'b10;
            end
            default: h_sub_o = 2'b00;
        endcase
    end
endmodule

// File: rtl/sat_simd_unit.sv
module sat_simd_unit
    import sat_simd_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter bit OUT_REG = 1'b1
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              valid_i,
    input  logic [2:0]        op_i,
    input  logic [DATA_W-1:0] src_a_i,
    input  logic [DATA_W-1:0] src_b_i,
    output logic              valid_o,
    output logic [DATA_W-1:0] result_o,
    output logic [3:0]        sat_o,
    output logic              illegal_o
);
    localparam int N_HALF = 2;
    localparam int N_BYTE = 4;
    localparam int HALF_W = DATA_W / N_HALF;
    localparam int BYTE_W = DATA_W / N_BYTE;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] result;
        logic [N_BYTE-1:0] sat;
        logic              illegal;
    } stage_t;

    logic [N_HALF-1:0][HALF_W-1:0] h_opa, h_opb, h_res;
    logic [N_HALF-1:0]             h_sub, h_sat;
    logic                          b_sub;
    logic [N_BYTE-1:0][BYTE_W-1:0] b_res;
    logic [N_BYTE-1:0]             b_sat;

    stage_t calc_c, stage_d, stage_q;

    sat_simd_route #(.HALF_W(HALF_W)) route_i (
        .op_i    (op_i),
        .src_a_i (src_a_i),
        .src_b_i (src_b_i),
        .h_opa_o (h_opa),
        .h_opb_o (h_opb),
        .h_sub_o (h_sub),
        .b_sub_o (b_sub)
    );

    for (genvar h = 0; h < N_HALF; h++) begin : g_half
        sat_addsub_lane #(.W(HALF_W)) lane_i (
            .opa_i (h_opa[h]),
            .opb_i (h_opb[h]),
            .sub_i (h_sub[h]),
            .res_o (h_res[h]),
            .sat_o (h_sat[h])
        );
    end

    for (genvar b = 0; b < N_BYTE; b++) begin : g_byte
        sat_addsub_lane #(.W(BYTE_W)) lane_i (
            .opa_i (src_a_i[b*BYTE_W +: BYTE_W]),
            .opb_i (src_b_i[b*BYTE_W +: BYTE_W]),
            .sub_i (b_sub),
            .res_o (b_res[b]),
            .sat_o (b_sat[b])
        );
    end

    always_comb begin
        calc_c       = '0;
        calc_c.valid = valid_i;
        if (op_is_reserved(op_i)) begin
            calc_c.illegal = 1'b1;
        end else if (op_is_byte(op_i)) begin
            calc_c.result = b_res;
            calc_c.sat    = b_sat;
        end else begin
            calc_c.result = h_res;
            for (int h = 0; h < N_HALF; h++) begin
                calc_c.sat[h*(N_BYTE/N_HALF)] = h_sat[h];
            end
        end
    end

    if (OUT_REG) begin : g_reg
        always_comb begin
            stage_d       = stage_q;
            stage_d.valid = valid_i;
            if (valid_i) begin
                stage_d = calc_c;
            end
        end

        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                stage_q <= '0;
            end else begin
                stage_q <= stage_d;
            end
        end
    end else begin : g_comb
        always_comb begin
            stage_d = calc_c;
            stage_q = stage_d;
        end
    end

    assign valid_o   = stage_q.valid;
    assign result_o  = stage_q.result;
    assign sat_o     = stage_q.sat;
    assign illegal_o = stage_q.illegal;
endmodule

// File: rtl/sat_simd_chk.sv
module sat_simd_chk #(
    parameter int DATA_W  = 32,
    parameter bit OUT_REG = 1'b1
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              valid_i,
    input logic [2:0]        op_i,
    input logic [DATA_W-1:0] src_a_i,
    input logic [DATA_W-1:0] src_b_i,
    input logic              valid_o,
    input logic [DATA_W-1:0] result_o,
    input logic [3:0]        sat_o,
    input logic              illegal_o
);
    if (OUT_REG) begin : g_chk
        AST_VALID_RISE: assert property (@(posedge clk_i) disable iff (rst_i)
            valid_i |=> valid_o); // R11
        AST_VALID_DROP: assert property (@(posedge clk_i) disable iff (rst_i)
            !valid_i |=> !valid_o); // R11
        AST_HOLD_OUT: assert property (@(posedge clk_i) disable iff (rst_i)
            !valid_i |=> ($stable(result_o) && $stable(sat_o) && $stable(illegal_o))); // R11
        AST_ILLEGAL_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
            illegal_o |-> (result_o == '0 && sat_o == '0)); // R10
        AST_ILLEGAL_CODE: assert property (@(posedge clk_i) disable iff (rst_i)
            (valid_i && (op_i == 3'd5 || op_i == 3'd6)) |=> illegal_o); // R10
        AST_LEGAL_CODE: assert property (@(posedge clk_i) disable iff (rst_i)
            (valid_i && op_i != 3'd5 && op_i != 3'd6) |=> !illegal_o); // R10
        AST_HALF_FLAGS: assert property (@(posedge clk_i) disable iff (rst_i)
            (valid_i && op_i < 3'd4) |=> (!sat_o[1] && !sat_o[3])); // R9
        AST_BYTE_CLAMP: assert property (@(posedge clk_i) disable iff (rst_i)
            (valid_i && (op_i == 3'd4 || op_i == 3'd7)) |=>
            (!sat_o[0] || result_o[7:0] == 8'h7F || result_o[7:0] == 8'h80)); // R8
        AST_ZERO_ADDEND: assert property (@(posedge clk_i) disable iff (rst_i)
            (valid_i && op_i == 3'd4 && src_b_i == '0) |=>
            (result_o == $past(src_a_i) && sat_o == 4'b0000)); // R6
    end
endmodule

bind sat_simd_unit sat_simd_chk #(.DATA_W(DATA_W), .OUT_REG(OUT_REG)) chk_i (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .valid_i   (valid_i),
    .op_i      (op_i),
    .src_a_i   (src_a_i),
    .src_b_i   (src_b_i),
    .valid_o   (valid_o),
    .result_o  (result_o),
    .sat_o     (sat_o),
    .illegal_o (illegal_o)
);

// File: tb/sat_simd_unit_tb_top.sv
module sat_simd_unit_tb_top;
    logic        clk_i = 1'b0;
    logic        rst_i = 1'b1;
    logic        valid_i = 1'b0;
    logic [2:0]  op_i = 3'd0;
    logic [31:0] src_a_i = '0;
    logic [31:0] src_b_i = '0;
    logic        valid_o;
    logic [31:0] result_o;
    logic [3:0]  sat_o;
    logic        illegal_o;

    int n_cmp  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk_i = ~clk_i;

    sat_simd_unit dut_i (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .valid_i   (valid_i),
        .op_i      (op_i),
        .src_a_i   (src_a_i),
        .src_b_i   (src_b_i),
        .valid_o   (valid_o),
        .result_o  (result_o),
        .sat_o     (sat_o),
        .illegal_o (illegal_o)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", req, got, exp);
        end
    endtask

    // wide-integer lane reference: exact result, then clamp to the signed range
    task automatic ref_lane(input int w, input logic [15:0] x, input logic [15:0] y,
                            input bit sub, output logic [15:0] r, output bit s);
        int xv, yv, sum, lo, hi;
        xv  = (w == 8) ? int'($signed(x[7:0])) : int'($signed(x));
        yv  = (w == 8) ? int'($signed(y[7:0])) : int'($signed(y));
        sum = sub ? xv - yv : xv + yv;
        hi  = (w == 8) ? 127 : 32767;
        lo  = -hi - 1;
        s   = 1'b0;
        if (sum > hi) begin sum = hi; s = 1'b1; end
        if (sum < lo) begin sum = lo; s = 1'b1; end
        r = 16'(sum);
    endtask

    task automatic ref_op(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                          output logic [31:0] r, output logic [3:0] s, output logic ill);
        logic [15:0] t0, t1;
        bit f0, f1;
        r = '0; s = '0; ill = 1'b0;
        case (op)
            3'd0: begin ref_lane(16, a[15:0], b[15:0], 0, t0, f0); ref_lane(16, a[31:16], b[31:16], 0, t1, f1); end
            3'd3: begin ref_lane(16, a[15:0], b[15:0], 1, t0, f0); ref_lane(16, a[31:16], b[31:16], 1, t1, f1); end
            3'd1: begin ref_lane(16, a[15:0], b[31:16], 1, t0, f0); ref_lane(16, a[31:16], b[15:0], 0, t1, f1); end
            3'd2: begin ref_lane(16, a[15:0], b[31:16], 0, t0, f0); ref_lane(16, a[31:16], b[15:0], 1, t1, f1); end
            default: begin t0 = '0; t1 = '0; f0 = 0; f1 = 0; end
        endcase
        if (op <= 3'd3) begin
            r = {t1, t0};
            s = {1'b0, f1, 1'b0, f0};
        end else if (op == 3'd4 || op == 3'd7) begin
            for (int i = 0; i < 4; i++) begin
                ref_lane(8, {8'h00, a[8*i +: 8]}, {8'h00, b[8*i +: 8]}, op == 3'd7, t0, f0);
                r[8*i +: 8] = t0[7:0];
                s[i] = f0;
            end
        end else begin
            ill = 1'b1;
        end
    endtask

    task automatic run_op(input string req, input logic [2:0] op,
                          input logic [31:0] a, input logic [31:0] b);
        logic [31:0] er;
        logic [3:0]  es;
        logic        ei;
        @(negedge clk_i);
        op_i = op; src_a_i = a; src_b_i = b; valid_i = 1'b1;
        @(posedge clk_i);
        @(negedge clk_i);
        valid_i = 1'b0;
        ref_op(op, a, b, er, es, ei);
        check({req, " result"}, result_o, er);
        check({req, " sat flags R9"}, {28'd0, sat_o}, {28'd0, es});
        check({req, " illegal R10"}, {31'd0, illegal_o}, {31'd0, ei});
        check({req, " valid_o R11"}, {31'd0, valid_o}, 32'd1);
    endtask

    task automatic t_reset();
        check("R1 valid_o", {31'd0, valid_o}, 32'd0);
        check("R1 result", result_o, 32'd0);
        check("R1 sat", {28'd0, sat_o}, 32'd0);
        check("R1 illegal", {31'd0, illegal_o}, 32'd0);
    endtask

    task automatic t_half_add();
        run_op("R2", 3'd0, 32'h0003_0005, 32'h0004_FFFE);
        check("R2 explicit", result_o, 32'h0007_0003);
        run_op("R2 R8 pos clamp", 3'd0, 32'h7FFF_1000, 32'h0001_2000);
        check("R8 hadd high clamp", result_o, 32'h7FFF_3000);
        run_op("R2 R8 neg clamp", 3'd0, 32'h0010_8000, 32'h0010_FFFF);
        check("R8 hadd low clamp", result_o, 32'h0020_8000);
        run_op("R2 mixed no clamp", 3'd0, 32'h7FFF_8000, 32'h8000_7FFF);
    endtask

    task automatic t_half_sub();
        run_op("R3", 3'd3, 32'h0009_0001, 32'h0002_0003);
        check("R3 explicit", result_o, 32'h0007_FFFE);
        run_op("R3 R8 clamp", 3'd3, 32'h8000_7FFF, 32'h0001_FFFF);
        check("R8 hsub both", result_o, 32'h8000_7FFF);
        run_op("R3 like signs", 3'd3, 32'h8000_7FFF, 32'h8000_7FFF);
    endtask

    task automatic t_cross();
        run_op("R4", 3'd1, 32'h0100_0200, 32'h0010_0020);
        check("R4 explicit", result_o, 32'h0120_01F0);
        run_op("R4 R8 clamp", 3'd1, 32'h7FF0_8000, 32'h0001_0100);
        check("R4 clamp explicit", result_o, 32'h7FFF_8000);
        run_op("R5", 3'd2, 32'h0100_0200, 32'h0010_0020);
        check("R5 explicit", result_o, 32'h00E0_0210);
        run_op("R5 R8 clamp", 3'd2, 32'h8000_7FFF, 32'h0001_0010);
        check("R5 clamp explicit", result_o, 32'h8000_7FFF);
    endtask

    task automatic t_bytes();
        run_op("R6", 3'd4, 32'h7F80_0102, 32'h0180_0304);
        check("R6 explicit", result_o, 32'h7F80_0406);
        check("R6 R9 lanes 2,3", {28'd0, sat_o}, 32'h0000_000C);
        run_op("R6 single lane", 3'd4, 32'h0000_0070, 32'h0000_0070);
        check("R9 lane0 only", {28'd0, sat_o}, 32'h0000_0001);
        run_op("R7", 3'd7, 32'h8005_7F10, 32'h0103_FF20);
        check("R7 explicit", result_o, 32'h8002_7FF0);
        run_op("R7 no borrow", 3'd7, 32'h0100_0100, 32'h0001_0001);
        check("R7 no borrow explicit", result_o, 32'h01FF_01FF);
    endtask

    task automatic t_illegal();
        run_op("R10 code5", 3'd5, 32'h7FFF_7FFF, 32'h0001_0001);
        check("R10 zero5", result_o, 32'h0);
        run_op("R10 code6", 3'd6, 32'hFFFF_FFFF, 32'h1234_5678);
        check("R10 zero6", result_o, 32'h0);
    endtask

    task automatic t_hold();
        logic [31:0] keep_r;
        logic [3:0]  keep_s;
        run_op("R11 load", 3'd4, 32'h7070_7070, 32'h2020_2020);
        keep_r = result_o;
        keep_s = sat_o;
        op_i = 3'd5; src_a_i = 32'hDEAD_BEEF; src_b_i = 32'h0BAD_F00D;
        repeat (3) @(negedge clk_i);
        check("R11 hold result", result_o, keep_r);
        check("R11 hold sat", {28'd0, sat_o}, {28'd0, keep_s});
        check("R11 hold illegal", {31'd0, illegal_o}, 32'd0);
        check("R11 valid_o low", {31'd0, valid_o}, 32'd0);
    endtask

    task automatic t_sweep();
        logic [31:0] a, b;
        logic [2:0]  op;
        for (int i = 0; i < 400; i++) begin
            a  = $urandom;
            b  = $urandom;
            op = 3'($urandom);
            if (i % 4 == 0) a[31] = ~b[31];
            run_op("R2-7 sweep R8", op, a, b);
        end
    endtask

    initial begin
        void'($urandom(32'h5A7C_0001));
        repeat (3) @(negedge clk_i);
        t_reset();
        rst_i = 1'b0;
        t_half_add();
        t_half_sub();
        t_cross();
        t_bytes();
        t_illegal();
        t_hold();
        t_sweep();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk_i);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    end
endmodule